// File: doc/BRIEF.md
# Capture Queue Sequencer

This block sits between a camera capture front end and a descriptor-chain DMA engine and decides when each of them runs. Software-side logic hands it frame buffer handles one at a time. The sequencer keeps them in an ordered queue, switches the capture front end on when work first arrives, and holds the DMA back until the next frame boundary. At that boundary it launches the chain at the oldest buffer. Every buffer accepted while the queue already holds work is appended to the running chain through a link command, so capture is never paused.

Each end-of-buffer indication from the DMA retires the oldest buffer, and its handle is reported on a done port. One cycle later the sequencer looks at the DMA. If the engine has fallen onto its stop address while buffers are still waiting, the last link arrived too late. The sequencer then restarts the DMA at the oldest waiting buffer. Because this test follows every completion, a halt that happens just after a test is caught at the next completion. When the queue drains, the capture front end is switched off. Requests are refused when the queue is full, or when a planar 4:2:2 frame has a pixel count that is not a multiple of 16.

Top module: `capq_sequencer`

## Requirements
- R1: While reset is high and in the first cycle after it, cap_en, dma_start, dma_link, done_valid, q_ack and q_err are all 0.
- R2: An accepted request while idle raises cap_en in the next cycle, without any dma_start or dma_link pulse.
- R3: dma_start with the oldest queued handle pulses one cycle after frame_end is sampled while armed (capture on, DMA not yet launched). frame_end in any other state has no effect.
- R4: A request accepted while the queue already holds at least one handle produces a one-cycle dma_link pulse carrying that request's handle in the next cycle. A request accepted into an empty queue produces no link.
- R5: dma_end sampled while the DMA runs (running or check state) and the queue is non-empty removes the oldest handle and pulses done_valid with it in the next cycle. Handles retire in acceptance order. dma_end while idle or armed has no effect.
- R6: In the check cycle after a completion, an empty queue drops cap_en in the following cycle. The exception is a request accepted in that same cycle: then cap_en stays high and the block re-arms to wait for frame_end.
- R7: In the check cycle, a non-empty queue with dma_halted high produces dma_start with the oldest handle in the next cycle. With dma_halted low, no dma_start is issued.
- R8: A dma_end that arrives during the check cycle retires a further handle and postpones the check by one cycle, so the test is made after every completion.
- R9: The queue holds at most DEPTH (default 8) handles. A request while it is full gets q_err and is not stored.
- R10: A request with q_planar=1 whose width times height is not divisible by 16 gets q_err and is not stored. With q_planar=0, any size is accepted.
- R11: Every cycle with q_valid high is answered in the next cycle by exactly one of q_ack or q_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| q_valid | input | 1 | Buffer queue request |
| q_handle | input | HW (4) | Handle of the offered buffer |
| q_planar | input | 1 | Offered frame uses the planar 4:2:2 layout |
| q_width | input | DW (12) | Frame width in pixels |
| q_height | input | DW (12) | Frame height in lines |
| q_ack | output | 1 | Request accepted (one cycle) |
| q_err | output | 1 | Request refused (one cycle) |
| frame_end | input | 1 | End-of-frame pulse from the capture front end |
| dma_end | input | 1 | DMA finished one buffer |
| dma_halted | input | 1 | DMA sits on its stop address |
| cap_en | output | 1 | Capture front end enable |
| dma_start | output | 1 | Launch DMA chain (one cycle) |
| dma_start_handle | output | HW (4) | Buffer at which the chain is launched |
| dma_link | output | 1 | Append a buffer to the chain tail (one cycle) |
| dma_link_handle | output | HW (4) | Buffer appended |
| done_valid | output | 1 | A buffer was retired (one cycle) |
| done_handle | output | HW (4) | Retired buffer |

## Verification
Every cycle, the assertions check the local rules. Each request gets exactly one reply, and a full queue always refuses. A done pulse is always preceded by dma_end, and a link always goes with an accept. A launch only happens while capture is on, and only right after a frame boundary or a completion. The end-to-end behaviour can only be shown by the bench's scenarios, which compare against a behavioural queue model: handles retiring in order, the late-link race in which a push coincides with the final completion, the halted and non-halted branches of the check, back-to-back completions, and the drain that switches capture off.

// File: rtl/cqs_pkg.sv
package cqs_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_ARMED = 2'd1,
        SQ_RUN   = 2'd2,
        SQ_CHECK = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic accept;
        logic reject;
    } admit_t;

    localparam int unsigned SIZE_GRAIN = 16;

    function automatic logic frame_size_ok(logic planar, logic [31:0] area);
        return !planar || ((area % SIZE_GRAIN) == 32'd0);
    endfunction

endpackage

// File: rtl/cqs_fifo.sv
module cqs_fifo #(
    parameter int DEPTH = 8,
    parameter int HW    = 4,
    localparam int CW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic          pop,
    input  logic [HW-1:0] din,
    output logic [HW-1:0] head,
    output logic [CW:0]   fill
);
    logic [HW-1:0] slots [DEPTH];
    logic [CW-1:0] rd_ptr, wr_ptr;

    function automatic logic [CW-1:0] bump(logic [CW-1:0] p);
        return (p == CW'(DEPTH - 1)) ? '0 : p + CW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            fill   <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            case ({push, pop})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_slot
            always_ff @(posedge clk) begin
                if (push && wr_ptr == CW'(i)) slots[i] <= din;
            end
        end
    endgenerate

    assign head = slots[rd_ptr];
endmodule

// File: rtl/cqs_admit.sv
module cqs_admit
    import cqs_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int DW    = 12,
    localparam int CW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          q_valid,
    input  logic          q_planar,
    input  logic [DW-1:0] q_width,
    input  logic [DW-1:0] q_height,
    input  logic [CW:0]   fill,
    output logic          accept,
    output logic          q_ack,
    output logic          q_err
);
    logic [31:0] area;
    admit_t      verdict;

    always_comb begin
        area           = 32'(q_width) * 32'(q_height);
        verdict.accept = q_valid && (fill != (CW+1)'(DEPTH))
                         && frame_size_ok(q_planar, area);
        verdict.reject = q_valid && !verdict.accept;
    end

    assign accept = verdict.accept;

    always_ff @(posedge clk) begin
        if (rst) begin
            q_ack <= 1'b0;
            q_err <= 1'b0;
        end else begin
            q_ack <= verdict.accept;
            q_err <= verdict.reject;
        end
    end
endmodule

// File: rtl/cqs_ctrl.sv
module cqs_ctrl
    import cqs_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int HW    = 4,
    localparam int CW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [HW-1:0] push_handle,
    input  logic [CW:0]   fill,
    input  logic [HW-1:0] head,
    input  logic          frame_end,
    input  logic          dma_end,
    input  logic          dma_halted,
    output logic          pop,
    output logic          cap_en,
    output logic          dma_start,
    output logic [HW-1:0] dma_start_handle,
    output logic          dma_link,
    output logic [HW-1:0] dma_link_handle,
    output logic          done_valid,
    output logic [HW-1:0] done_handle
);
    seq_state_e state, nxt;
    logic       launch;
    logic       has_work;

    assign has_work = (fill != '0);
    assign pop = dma_end && has_work && (state == SQ_RUN || state == SQ_CHECK);

    always_comb begin
        nxt    = state;
        launch = 1'b0;
        unique case (state)
            SQ_IDLE:  if (push) nxt = SQ_ARMED;
            SQ_ARMED: if (frame_end) begin
                          nxt    = SQ_RUN;
                          launch = 1'b1;
                      end
            SQ_RUN:   if (pop) nxt = SQ_CHECK;
            SQ_CHECK: begin
                if (pop) begin
                    nxt = SQ_CHECK;
                end else if (!has_work) begin
                    nxt = push ? SQ_ARMED : SQ_IDLE;
                end else begin
                    nxt    = SQ_RUN;
                    launch = dma_halted;
                end
            end
            default:  nxt = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state            <= SQ_IDLE;
            cap_en           <= 1'b0;
            dma_start        <= 1'b0;
            dma_start_handle <= '0;
            dma_link         <= 1'b0;
            dma_link_handle  <= '0;
            done_valid       <= 1'b0;
            done_handle      <= '0;
        end else begin
            state            <= nxt;
            cap_en           <= (nxt != SQ_IDLE);
            dma_start        <= launch;
            dma_start_handle <= head;
            dma_link         <= push && has_work;
            dma_link_handle  <= push_handle;
            done_valid       <= pop;
            done_handle      <= head;
        end
    end
endmodule

// File: rtl/capq_sequencer.sv
module capq_sequencer
    import cqs_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int HW    = 4,
    parameter int DW    = 12,
    localparam int CW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          q_valid,
    input  logic [HW-1:0] q_handle,
    input  logic          q_planar,
    input  logic [DW-1:0] q_width,
    input  logic [DW-1:0] q_height,
    output logic          q_ack,
    output logic          q_err,
    input  logic          frame_end,
    input  logic          dma_end,
    input  logic          dma_halted,
    output logic          cap_en,
    output logic          dma_start,
    output logic [HW-1:0] dma_start_handle,
    output logic          dma_link,
    output logic [HW-1:0] dma_link_handle,
    output logic          done_valid,
    output logic [HW-1:0] done_handle
);
    logic          accept;
    logic          pop;
    logic [CW:0]   fill;
    logic [HW-1:0] head;

    cqs_admit #(.DEPTH(DEPTH), .DW(DW)) u_admit (
        .clk(clk), .rst(rst), .q_valid(q_valid), .q_planar(q_planar),
        .q_width(q_width), .q_height(q_height), .fill(fill),
        .accept(accept), .q_ack(q_ack), .q_err(q_err)
    );

    cqs_fifo #(.DEPTH(DEPTH), .HW(HW)) u_fifo (
        .clk(clk), .rst(rst), .push(accept), .pop(pop),
        .din(q_handle), .head(head), .fill(fill)
    );

    cqs_ctrl #(.DEPTH(DEPTH), .HW(HW)) u_ctrl (
        .clk(clk), .rst(rst), .push(accept), .push_handle(q_handle),
        .fill(fill), .head(head), .frame_end(frame_end), .dma_end(dma_end),
        .dma_halted(dma_halted), .pop(pop), .cap_en(cap_en),
        .dma_start(dma_start), .dma_start_handle(dma_start_handle),
        .dma_link(dma_link), .dma_link_handle(dma_link_handle),
        .done_valid(done_valid), .done_handle(done_handle)
    );
endmodule

// File: rtl/cqs_checker.sv
module cqs_checker #(
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH)
) (
    input logic        clk,
    input logic        rst,
    input logic        q_valid,
    input logic        q_ack,
    input logic        q_err,
    input logic        frame_end,
    input logic        dma_end,
    input logic        cap_en,
    input logic        dma_start,
    input logic        dma_link,
    input logic        done_valid,
    input logic [CW:0] fill
);
    assert_reply_once_R11: assert property (@(posedge clk) disable iff (rst)
        !(q_ack && q_err));
    assert_reply_follows_R11: assert property (@(posedge clk) disable iff (rst)
        q_valid |=> (q_ack || q_err));
    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
        fill <= (CW+1)'(DEPTH));
    assert_full_refused_R9: assert property (@(posedge clk) disable iff (rst)
        (q_valid && fill == (CW+1)'(DEPTH)) |=> q_err);
    assert_cap_rise_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(cap_en) |-> $past(q_valid));
    assert_launch_cause_R3: assert property (@(posedge clk) disable iff (rst)
        dma_start |-> ($past(frame_end) || $past(done_valid)));
    assert_launch_cap_R7: assert property (@(posedge clk) disable iff (rst)
        dma_start |-> cap_en);
    assert_link_accept_R4: assert property (@(posedge clk) disable iff (rst)
        dma_link |-> q_ack);
    assert_done_cause_R5: assert property (@(posedge clk) disable iff (rst)
        done_valid |-> $past(dma_end));
endmodule

bind capq_sequencer cqs_checker #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst(rst), .q_valid(q_valid), .q_ack(q_ack), .q_err(q_err),
    .frame_end(frame_end), .dma_end(dma_end), .cap_en(cap_en),
    .dma_start(dma_start), .dma_link(dma_link), .done_valid(done_valid),
    .fill(fill)
);

// File: tb/capq_sequencer_bench.sv
`timescale 1ns/1ps
module capq_sequencer_bench;
    localparam int HW = 4;
    localparam int DW = 12;

    logic clk = 0;
    logic rst = 1;
    logic q_valid = 0, q_planar = 0, frame_end = 0, dma_end = 0, dma_halted = 0;
    logic [HW-1:0] q_handle = '0;
    logic [DW-1:0] q_width = '0, q_height = '0;
    logic q_ack, q_err, cap_en, dma_start, dma_link, done_valid;
    logic [HW-1:0] dma_start_handle, dma_link_handle, done_handle;

    int checks = 0, errors = 0;
    bit ended = 0, seen_edge = 0;

    always #4 clk = ~clk;

    capq_sequencer u_capq_sequencer (
        .clk(clk), .rst(rst), .q_valid(q_valid), .q_handle(q_handle),
        .q_planar(q_planar), .q_width(q_width), .q_height(q_height),
        .q_ack(q_ack), .q_err(q_err), .frame_end(frame_end), .dma_end(dma_end),
        .dma_halted(dma_halted), .cap_en(cap_en), .dma_start(dma_start),
        .dma_start_handle(dma_start_handle), .dma_link(dma_link),
        .dma_link_handle(dma_link_handle), .done_valid(done_valid),
        .done_handle(done_handle)
    );

    // behavioural reference: 0 idle, 1 armed, 2 running, 3 check
    int m_st;
    int mq[$];
    bit e_ack, e_err, e_cap, e_start, e_link, e_done;
    int e_sh, e_lh, e_dh;

    always @(posedge clk) begin
        int cnt, nst;
        bit ok, pop, area_ok;
        seen_edge = 1;
        if (rst) begin
            m_st = 0; mq.delete();
            {e_ack, e_err, e_cap, e_start, e_link, e_done} = '0;
        end else begin
            cnt = mq.size();
            area_ok = !q_planar || ((int'(q_width) * int'(q_height)) % 16 == 0);
            ok  = q_valid && cnt < 8 && area_ok;
            pop = dma_end && cnt > 0 && (m_st == 2 || m_st == 3);
            e_ack = ok; e_err = q_valid && !ok;
            e_link = ok && cnt > 0; e_lh = q_handle;
            e_done = pop; if (pop) e_dh = mq[0];
            e_start = 0; nst = m_st;
            case (m_st)
                0: if (ok) nst = 1;
                1: if (frame_end) begin nst = 2; e_start = 1; e_sh = mq[0]; end
                2: if (pop) nst = 3;
                default: begin
                    if (pop) nst = 3;
                    else if (cnt == 0) nst = ok ? 1 : 0;
                    else begin
                        nst = 2;
                        if (dma_halted) begin e_start = 1; e_sh = mq[0]; end
                    end
                end
            endcase
            m_st = nst; e_cap = (nst != 0);
            if (pop) void'(mq.pop_front());
            if (ok) mq.push_back(int'(q_handle));
        end
    end

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (seen_edge && !ended) begin
            check("R11", "q_ack", int'(q_ack), int'(e_ack));
            check("R11", "q_err", int'(q_err), int'(e_err));
            check("R6",  "cap_en", int'(cap_en), int'(e_cap));
            check("R3",  "dma_start", int'(dma_start), int'(e_start));
            if (e_start) check("R7", "start handle", int'(dma_start_handle), e_sh);
            check("R4",  "dma_link", int'(dma_link), int'(e_link));
            if (e_link) check("R4", "link handle", int'(dma_link_handle), e_lh);
            check("R5",  "done_valid", int'(done_valid), int'(e_done));
            if (e_done) check("R5", "done handle", int'(done_handle), e_dh);
        end
    end

    task automatic offer(int h, bit planar, int w, int hgt);
        q_valid = 1; q_handle = HW'(h); q_planar = planar;
        q_width = DW'(w); q_height = DW'(hgt);
    endtask

    task automatic step();
        @(negedge clk);
        q_valid = 0; frame_end = 0; dma_end = 0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!ended) begin
            ended = 1; checks++; errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(3);
        check("R1", "cap_en in reset", int'(cap_en), 0);
        check("R1", "dma_start in reset", int'(dma_start), 0);
        rst = 0;
        step();
        check("R1", "done_valid after reset", int'(done_valid), 0);
        check("R1", "q_ack after reset", int'(q_ack), 0);

        // frame_end and dma_end while idle: no effect
        frame_end = 1; dma_end = 1; step();
        check("R3", "start while idle", int'(dma_start), 0);
        check("R5", "done while idle", int'(done_valid), 0);

        // first buffer: armed, no DMA yet
        offer(3, 1, 16, 4); step();
        check("R2", "cap_en after first accept", int'(cap_en), 1);
        check("R2", "no link on first", int'(dma_link), 0);
        dma_end = 1; step();
        check("R5", "end while armed ignored", int'(done_valid), 0);
        offer(5, 0, 7, 3); step();
        check("R4", "link while armed", int'(dma_link), 1);
        offer(6, 1, 5, 3); step();
        check("R10", "planar 15 px refused", int'(q_err), 1);
        offer(9, 0, 5, 3); step();
        check("R10", "packed odd size taken", int'(q_ack), 1);
        idle(2);
        frame_end = 1; step();
        check("R3", "launch on frame end", int'(dma_start), 1);
        check("R3", "launch handle", int'(dma_start_handle), 3);
        frame_end = 1; step();
        check("R3", "frame end while running", int'(dma_start), 0);

        // completion, DMA still moving
        dma_end = 1; step();
        check("R5", "first retire", int'(done_handle), 3);
        step();
        check("R7", "no restart when running", int'(dma_start), 0);

        // back-to-back completions
        dma_end = 1; step();
        dma_end = 1; step();
        check("R8", "second retire", int'(done_handle), 9);
        dma_halted = 1; step();
        check("R6", "drained: capture off", int'(cap_en), 0);
        check("R8", "no start on empty", int'(dma_start), 0);
        dma_halted = 0; idle(2);

        // late link race: push coincides with final completion
        offer(1, 0, 8, 8); step();
        frame_end = 1; step();
        idle(2);
        offer(2, 0, 8, 8); dma_end = 1; step();
        check("R4", "late link issued", int'(dma_link), 1);
        dma_halted = 1; step();
        check("R7", "link-miss restart", int'(dma_start), 1);
        check("R7", "restart handle", int'(dma_start_handle), 2);
        dma_halted = 0; idle(2);
        dma_end = 1; step();
        offer(4, 0, 2, 2); step();
        check("R6", "re-armed by push in check", int'(cap_en), 1);
        check("R6", "no start on re-arm", int'(dma_start), 0);
        idle(2);

        // fill to capacity while armed
        for (int i = 0; i < 8; i++) begin offer(8 + i, 0, 4, 4); step(); end
        check("R9", "ninth refused", int'(q_err), 1);
        frame_end = 1; step();
        for (int i = 0; i < 8; i++) begin dma_end = 1; step(); step(); end
        idle(3);
        check("R6", "capture off after drain", int'(cap_en), 0);

        ended = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule